// File: doc/BRIEF.md
# Zero-Crossing Triggered Dual-Buffer Capture

This block records one window of audio samples into two buffer memories at once. One copy feeds a screen renderer and the other feeds a frequency transform. An internal interval timer raises a start request at a fixed period. The request arms the block, but writing does not begin until the audio waveform next passes upward through zero. Each window therefore begins at the same phase of the waveform, so successive captures line up on a display.

Input samples are signed 16-bit words, each qualified by a one-cycle valid strobe. For every valid sample in the window, the block drives the same address, byte and write enable to both buffer ports in the same cycle, so the two copies are always identical. A busy flag covers the time from arming to completion. A one-cycle done pulse marks the end of the window.

Top module: `zc_capture_ctrl`

## Requirements
- R1: A start request occurs once every TICK_CYCLES clock cycles. The first request falls in the cycle after TICK_CYCLES-1 rising edges following reset release, so busy first reads high after exactly TICK_CYCLES edges.
- R2: A start request in the idle state arms the block. busy is high from the arming edge until the window completes, and no write occurs while the block is armed until a rising crossing arrives.
- R3: A rising crossing is a valid sample whose value is zero or positive (bit 15 clear) when the previous valid sample was negative (bit 15 set). Zero counts as non-negative. A falling crossing never starts a capture.
- R4: The previous-sample history includes samples that arrive before arming. If the last sample before arming was negative and the first sample after arming is non-negative, capture starts with that first sample.
- R5: The crossing sample itself is written at address 0, in the same cycle as its valid strobe.
- R6: The window holds DEPTH (default 1024) samples at consecutive addresses 0 to DEPTH-1, one per valid strobe. No write occurs in a cycle without a valid strobe.
- R7: The stored byte is bits [15:8] of the 16-bit sample.
- R8: Both buffer ports carry the same write enable, address and byte in every cycle.
- R9: done is high for exactly one cycle, the cycle after address DEPTH-1 is written. busy is low in that cycle.
- R10: A start request that arrives while armed or capturing does not disturb the window: addresses stay consecutive and the window completes normally.
- R11: After reset, busy, done and both write enables are low. Samples received while idle cause no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | 16 | Signed audio sample |
| smp_vld | input | 1 | Sample qualifier, one cycle per sample |
| disp_we | output | 1 | Write enable, display buffer |
| disp_addr | output | 10 | Write address, display buffer |
| disp_data | output | 8 | Write byte, display buffer |
| xfrm_we | output | 1 | Write enable, transform buffer |
| xfrm_addr | output | 10 | Write address, transform buffer |
| xfrm_data | output | 8 | Write byte, transform buffer |
| busy | output | 1 | Armed or capturing |
| done | output | 1 | One-cycle end-of-window pulse |

## Verification
The trigger is tried with four waveforms, each chosen to separate one trigger rule from its likely misreadings:
- A square wave separates rising from falling edges.
- A slow ramp places the crossing deep into the stream, which exposes an early or late trigger.
- An alternation between a small negative value and exactly zero shows whether zero counts as non-negative.
- A stretch of distinct negative values followed by positives exposes a trigger that ignores the sign history.

Directed runs cover further cases. One holds the block armed through all-positive and then all-negative input, with a start request landing in that time. Another places the negative half of a crossing before arming. The remaining runs cover reset and idle input.

// File: rtl/zcap_pkg.sv
package zcap_pkg;
   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_ARMED = 2'd1,
      CS_FILL  = 2'd2,
      CS_FIN   = 2'd3
   } cap_state_t;
endpackage

// File: rtl/zcap_interval_timer.sv
module zcap_interval_timer #(
   parameter int unsigned TICK_CYCLES = 10_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

   generate
      if (TICK_CYCLES < 2) begin : g_bad_period
         $error("TICK_CYCLES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R1
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/zcap_cross_detect.sv
module zcap_cross_detect #(
   parameter int unsigned SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] smp,
   input  logic                vld,
   output logic                rise
);
   logic prev_neg_q;
   logic cur_neg;

   assign cur_neg = ($signed(smp) < 0);
   assign rise    = vld && prev_neg_q && !cur_neg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_neg_q <= 1'b0;
      else if (vld)  prev_neg_q <= cur_neg;
   end

   // R3
   rise_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> (vld && !smp[SAMPLE_W-1]));
endmodule

// File: rtl/zcap_fsm.sv
module zcap_fsm
   import zcap_pkg::*;
#(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              vld,
   input  logic              rise,
   output logic              we,
   output logic [ADDR_W-1:0] addr,
   output logic              busy,
   output logic              done
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   cap_state_t        st_q;
   logic [ADDR_W-1:0] addr_q;

   always_comb begin
      we = 1'b0;
      unique case (st_q)
         CS_ARMED: we = rise;
         CS_FILL:  we = vld;
         default:  we = 1'b0;
      endcase
   end

   assign addr = (st_q == CS_ARMED) ? '0 : addr_q;
   assign busy = (st_q == CS_ARMED) || (st_q == CS_FILL);
   assign done = (st_q == CS_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CS_IDLE;
         addr_q <= '0;
      end else begin
         unique case (st_q)
            CS_IDLE:  if (tick) st_q <= CS_ARMED;
            CS_ARMED: if (rise) begin
               addr_q <= ADDR_W'(1);
               st_q   <= CS_FILL;
            end
            CS_FILL:  if (vld) begin
               if (addr_q == LAST) st_q <= CS_FIN;
               else                addr_q <= addr_q + 1'b1;
            end
            default: begin
               st_q   <= CS_IDLE;
               addr_q <= '0;
            end
         endcase
      end
   end

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(we) && ($past(addr) == LAST)));

   // R6
   write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> vld);

   // R2
   write_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> busy);

   // R10
   tick_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick) |=> (busy || done));
endmodule

// File: rtl/zc_capture_ctrl.sv
module zc_capture_ctrl #(
   parameter int unsigned SAMPLE_W    = 16,
   parameter int unsigned STORE_W     = 8,
   parameter int unsigned DEPTH       = 1024,
   parameter int unsigned TICK_CYCLES = 10_000_000,
   localparam int unsigned ADDR_W     = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] smp_in,
   input  logic                smp_vld,
   output logic                disp_we,
   output logic [ADDR_W-1:0]   disp_addr,
   output logic [STORE_W-1:0]  disp_data,
   output logic                xfrm_we,
   output logic [ADDR_W-1:0]   xfrm_addr,
   output logic [STORE_W-1:0]  xfrm_data,
   output logic                busy,
   output logic                done
);
   generate
      if (STORE_W > SAMPLE_W || STORE_W == 0) begin : g_bad_width
         $error("STORE_W must be between 1 and SAMPLE_W");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 2");
      end
   endgenerate

   logic              tick;
   logic              rise;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [STORE_W-1:0] wr_byte;

   zcap_interval_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   zcap_cross_detect #(.SAMPLE_W(SAMPLE_W)) u_cross (
      .clk  (clk),
      .rst_n(rst_n),
      .smp  (smp_in),
      .vld  (smp_vld),
      .rise (rise)
   );

   zcap_fsm #(.DEPTH(DEPTH)) u_fsm (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .vld  (smp_vld),
      .rise (rise),
      .we   (wr_en),
      .addr (wr_addr),
      .busy (busy),
      .done (done)
   );

   generate
      if (STORE_W == SAMPLE_W) begin : g_full
         assign wr_byte = smp_in;
      end else begin : g_upper
         assign wr_byte = smp_in[SAMPLE_W-1 -: STORE_W];
      end
   endgenerate

   assign disp_we   = wr_en;
   assign disp_addr = wr_addr;
   assign disp_data = wr_byte;
   assign xfrm_we   = wr_en;
   assign xfrm_addr = wr_addr;
   assign xfrm_data = wr_byte;

   // R5
   first_write_crossing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_we && disp_addr == '0) |-> (smp_vld && !smp_in[SAMPLE_W-1]));

   // R11
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy) |-> !(disp_we || xfrm_we));
endmodule

// File: tb/sim_zc_capture_ctrl.sv
module sim_zc_capture_ctrl;
   localparam int P     = 1500;
   localparam int DEPTH = 1024;
   localparam int NVEC  = 4;
   localparam int V_KIND  [NVEC] = '{0, 1, 2, 3};
   localparam int V_START [NVEC] = '{4, 207, 1, 12};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] smp_in = '0;
   logic        smp_vld = 1'b0;
   logic        disp_we, xfrm_we, busy, done;
   logic [9:0]  disp_addr, xfrm_addr;
   logic [7:0]  disp_data, xfrm_data;

   int n_chk = 0;
   int n_fail = 0;
   int wcount;
   int first_idx;
   logic [7:0] mem_a [DEPTH];
   logic [7:0] mem_b [DEPTH];

   always #10 clk = ~clk;

   zc_capture_ctrl #(.TICK_CYCLES(P)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_vld(smp_vld),
      .disp_we(disp_we), .disp_addr(disp_addr), .disp_data(disp_data),
      .xfrm_we(xfrm_we), .xfrm_addr(xfrm_addr), .xfrm_data(xfrm_data),
      .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] wave(input int kind, input int i);
      int v;
      case (kind)
         0: v = ((i % 8) < 4) ? -1000 : 1000;
         1: begin
            v = -20000 + 97 * i;
            if (v > 32767) v = 32767;
         end
         2: v = ((i % 2) == 0) ? -5 : 0;
         3: v = (i < 12) ? -(i + 1) * 50 : (i % 10) * 10 + 1;
         default: v = 700;
      endcase
      return v[15:0];
   endfunction

   // one sample: valid cycle then gap cycle, both observed at negedge
   task automatic send_obs(input logic [15:0] v, input int idx);
      bit finished = 1'b0;
      @(posedge clk); #1;
      smp_in = v; smp_vld = 1'b1;
      @(negedge clk);
      if (disp_we) begin
         if (wcount == 0) first_idx = idx;
         chk(int'(disp_addr) == wcount, "R6", "write address", int'(disp_addr), wcount);
         chk(xfrm_we && xfrm_addr == disp_addr && xfrm_data == disp_data,
             "R8", "copy mismatch", int'(xfrm_data), int'(disp_data));
         if (wcount < DEPTH) begin
            mem_a[wcount] = disp_data;
            mem_b[wcount] = xfrm_data;
         end
         wcount++;
         if (wcount == DEPTH) finished = 1'b1;
      end
      @(posedge clk); #1;
      smp_vld = 1'b0;
      @(negedge clk);
      chk(!disp_we && !xfrm_we, "R6", "write without valid", int'(disp_we), 0);
      if (finished) begin
         chk(done == 1'b1, "R9", "done after last write", int'(done), 1);
         chk(busy == 1'b0, "R9", "busy low with done", int'(busy), 0);
      end
   endtask

   task automatic wait_busy();
      int guard = 0;
      while (!busy && guard < 4 * P) begin
         @(negedge clk);
         guard++;
      end
      chk(busy == 1'b1, "R2", "armed by start request", int'(busy), 1);
   endtask

   task automatic run_vector(input int kind, input int exp_start, input string req);
      int bad = 0;
      int bad_j = -1;
      wait_busy();
      wcount = 0;
      first_idx = -1;
      for (int i = 0; wcount < DEPTH && i < DEPTH + 400; i++)
         send_obs(wave(kind, i), i);
      chk(wcount == DEPTH, "R10", "window length", wcount, DEPTH);
      chk(first_idx == exp_start, req, "capture start index", first_idx, exp_start);
      @(posedge clk); @(negedge clk);
      chk(done == 1'b0, "R9", "done one cycle only", int'(done), 0);
      for (int j = 0; j < DEPTH; j++) begin
         logic [15:0] s;
         s = wave(kind, exp_start + j);
         if (mem_a[j] !== s[15:8] || mem_b[j] !== s[15:8]) begin
            bad++;
            if (bad_j < 0) bad_j = j;
         end
      end
      chk(bad == 0, "R7", "stored upper byte mismatches (first index in actual)", bad_j, -1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      // R11: reset state
      repeat (3) @(negedge clk);
      chk(!busy && !done && !disp_we && !xfrm_we, "R11", "reset outputs",
          int'({busy, done, disp_we, xfrm_we}), 0);
      rst_n = 1'b1;

      // R1: first start request arms after exactly P edges
      repeat (P - 1) @(posedge clk);
      @(negedge clk);
      chk(busy == 1'b0, "R1", "busy before first request", int'(busy), 0);
      @(posedge clk); @(negedge clk);
      chk(busy == 1'b1, "R1", "busy after P edges", int'(busy), 1);

      // R2 / R10: armed, no rising crossing, a start request lands meanwhile
      wcount = 0;
      first_idx = -1;
      for (int i = 0; i < 400; i++) send_obs(16'd500, i);
      for (int i = 0; i < 400; i++) send_obs(-16'sd500, i);
      chk(wcount == 0, "R3", "no write without rising crossing", wcount, 0);
      chk(busy == 1'b1, "R10", "still armed after extra request", int'(busy), 1);

      // table of waveforms (R3, R5)
      for (int v = 0; v < NVEC; v++)
         run_vector(V_KIND[v], V_START[v], "R3");

      // R11: idle samples ignored; negative sample before arming (R4)
      wcount = 0;
      send_obs(-16'sd700, 0);
      chk(wcount == 0, "R11", "idle sample write", wcount, 0);
      run_vector(4, 0, "R4");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule